// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits between an instruction fetch buffer and an execution stage. Each cycle the fetch side may present a window of five consecutive instruction bytes read at the block's current program counter. The block classifies the instruction from its leading byte into one of six length classes, one to five bytes long. It rearranges the bytes of that class into a normalized 32-bit word plus an 8-bit side byte, and moves its program counter forward by the instruction length.

The program counter lives inside the block and is shown to the fetch side as `fetch_pc`, so the fetch side knows where to read the next window. Arithmetic on it wraps inside a 19-bit address space. A one-entry output register with a valid/ready handshake holds each decoded instruction together with its own address and the address that follows it. A new window is taken whenever that register is empty or is being emptied in the same cycle.

Top module: `vlid_fetch_decoder`

## Requirements
- R1: While `rst_n` is low on a clock edge, `out_valid` goes to 0, `in_ready` reads 1 afterwards, and `fetch_pc` is loaded from `start_pc`.
- R2: Lead bytes 0x00–0x3F, 0x90–0xBF, 0xEB, 0xF6, 0xFE and 0xFF give length 1, with word = lead byte zero-extended to 32 bits.
- R3: For lead bytes 0x80–0x8F, length is 2 when bits [3:2] equal bits [1:0] (0x80, 0x85, 0x8A, 0x8F), with word = {16'h0, byte0, byte1}; otherwise length is 1, with word = lead byte zero-extended.
- R4: Lead bytes 0x40–0x7F, 0xD0–0xDB, 0xE0–0xEA and 0xF0–0xF3 give length 2, with word = {16'h0, byte0, byte1}.
- R5: Lead bytes 0xC0–0xCF, 0xDC–0xDF, 0xEC–0xEF and 0xF8–0xFD give length 3, with word = {8'h0, byte0, byte2, byte1}, a little-endian operand after the lead.
- R6: Lead byte 0xF5 gives length 3, with word = {8'h0, byte0, byte1, byte2} in stream order.
- R7: Lead byte 0xF7 gives length 4, with word = {byte0, byte1, byte3, byte2}.
- R8: Lead byte 0xF4 gives length 5, with word = {byte0, byte1, byte4, byte3} and `out_ext` = byte2. For every other length `out_ext` is 0.
- R9: For each decoded instruction, `out_pc` is the address the window was read at, `out_next_pc` = (`out_pc` + `out_len`) mod 2^19, and `fetch_pc` moves to that value when the window is accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value, `in_ready` is 0, and `fetch_pc` does not change.
- R11: When `out_valid` and `out_ready` are both 1 and `in_valid` is 1, the window is accepted in the same cycle, and the next decoded instruction appears on the following cycle with no empty cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pc | input | 19 | Program counter value loaded during reset |
| in_valid | input | 1 | Window of bytes is present |
| in_ready | output | 1 | Block takes the window this cycle |
| in_bytes | input | 40 | Five instruction bytes; byte k at bits [8k+7:8k], byte 0 at `fetch_pc` |
| fetch_pc | output | 19 | Address the next window must be read from |
| out_valid | output | 1 | Decoded instruction is held |
| out_ready | input | 1 | Consumer takes the decoded instruction |
| out_word | output | 32 | Normalized instruction word |
| out_ext | output | 8 | Extension byte (5-byte instructions only) |
| out_len | output | 3 | Instruction length in bytes, 1 to 5 |
| out_pc | output | 19 | Address of the decoded instruction |
| out_next_pc | output | 19 | Address following the decoded instruction |

## Verification
A misclassified lead byte gives the wrong length and packing on the very next output, and from then on `fetch_pc` is off. Every later `out_pc` is displaced, so one length error shows on the same output and also on all the ones after it. The bench therefore sweeps all 256 lead bytes in one continuous stream against an arithmetic model. A broken hold or a broken accept condition shows within one cycle of back-pressure, as a changed field, a raised `in_ready` or a moved `fetch_pc`.

// File: rtl/vlid_pkg.sv
// Shared widths and types for the variable-length fetch decoder.
// Assumes byte 0 of a window is the byte at the current program counter.
package vlid_pkg;
    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 5;
    localparam int WIN_W     = WIN_BYTES * BYTE_W;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 3;

    // Length/packing class selected by the lead byte.
    typedef enum logic [2:0] {
        CLS_ONE,
        CLS_TWO,
        CLS_THREE_LE,
        CLS_THREE_SEQ,
        CLS_FOUR,
        CLS_FIVE
    } ilen_cls_t;

    // One decoded instruction before address fields are attached.
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [BYTE_W-1:0] ext;
        logic [LEN_W-1:0]  len;
    } dec_res_t;
endpackage

// File: rtl/vlid_len_classify.sv
// Maps a lead byte onto a length/packing class.
// Purely combinational; every one of the 256 byte values maps to exactly one class.
module vlid_len_classify
    import vlid_pkg::*;
(
    input  logic [BYTE_W-1:0] lead,
    output ilen_cls_t         cls
);
    // Decode by high nibble, then refine on the low nibble.
    always_comb begin
        cls = CLS_ONE;
        unique case (lead[7:4])
            4'h4, 4'h5, 4'h6, 4'h7: cls = CLS_TWO;
            4'h8:    cls = (lead[3:2] == lead[1:0]) ? CLS_TWO : CLS_ONE;
            4'hC:    cls = CLS_THREE_LE;
            4'hD:    cls = (lead[3:2] == 2'b11) ? CLS_THREE_LE : CLS_TWO;
            4'hE: begin
                if (lead[3:2] == 2'b11)   cls = CLS_THREE_LE;
                else if (lead[3:0] == 4'hB) cls = CLS_ONE;
                else                      cls = CLS_TWO;
            end
            4'hF: begin
                unique case (lead[3:0])
                    4'h0, 4'h1, 4'h2, 4'h3: cls = CLS_TWO;
                    4'h4:                   cls = CLS_FIVE;
                    4'h5:                   cls = CLS_THREE_SEQ;
                    4'h7:                   cls = CLS_FOUR;
                    4'h6, 4'hE, 4'hF:       cls = CLS_ONE;
                    default:                cls = CLS_THREE_LE;
                endcase
            end
            default: cls = CLS_ONE;
        endcase
    end
endmodule

// File: rtl/vlid_pack.sv
// Rearranges window bytes into the normalized word, extension and length
// for a given class. Combinational; unused window bytes are ignored.
module vlid_pack
    import vlid_pkg::*;
(
    input  logic [WIN_W-1:0] window,
    input  ilen_cls_t        cls,
    output dec_res_t         res
);
    logic [BYTE_W-1:0] b [WIN_BYTES];

    // Split the flat window into bytes, byte 0 lowest.
    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_split
        assign b[k] = window[k*BYTE_W +: BYTE_W];
    end

    // Select layout per class.
    always_comb begin
        res.ext = '0;
        unique case (cls)
            CLS_TWO: begin
                res.word = {16'h0, b[0], b[1]};
                res.len  = 3'd2;
            end
            CLS_THREE_LE: begin
                res.word = {8'h0, b[0], b[2], b[1]};
                res.len  = 3'd3;
            end
            CLS_THREE_SEQ: begin
                res.word = {8'h0, b[0], b[1], b[2]};
                res.len  = 3'd3;
            end
            CLS_FOUR: begin
                res.word = {b[0], b[1], b[3], b[2]};
                res.len  = 3'd4;
            end
            CLS_FIVE: begin
                res.word = {b[0], b[1], b[4], b[3]};
                res.ext  = b[2];
                res.len  = 3'd5;
            end
            default: begin
                res.word = {24'h0, b[0]};
                res.len  = 3'd1;
            end
        endcase
    end
endmodule

// File: rtl/vlid_out_stage.sv
// One-entry output register with valid/ready handshake.
// Assumes load is only asserted when the entry is empty or being drained.
module vlid_out_stage
    import vlid_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  dec_res_t          res_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] next_in,
    input  logic              drain,
    output logic              valid,
    output dec_res_t          res_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] next_q
);
    // Valid flag: set on load, cleared when drained without a refill.
    always_ff @(posedge clk) begin
        if (!rst_n)        valid <= 1'b0;
        else if (load)     valid <= 1'b1;
        else if (drain)    valid <= 1'b0;
    end

    // Payload: captured only on load, otherwise held.
    always_ff @(posedge clk) begin
        if (load) begin
            res_q  <= res_in;
            pc_q   <= pc_in;
            next_q <= next_in;
        end
    end
endmodule

// File: rtl/vlid_fetch_decoder.sv
// Top: accepts a five-byte window at fetch_pc, decodes length and packing,
// registers the result and advances the program counter by the length.
// Assumes ADDR_W exceeds the length width; PC wraps modulo 2^ADDR_W.
module vlid_fetch_decoder
    import vlid_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_pc,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WIN_W-1:0]  in_bytes,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [BYTE_W-1:0] out_ext,
    output logic [LEN_W-1:0]  out_len,
    output logic [ADDR_W-1:0] out_pc,
    output logic [ADDR_W-1:0] out_next_pc
);
    localparam int PAD_W = ADDR_W - LEN_W;

    ilen_cls_t         cls;
    dec_res_t          dec, held;
    logic              accept;
    logic [ADDR_W-1:0] pc_q, pc_next;

    vlid_len_classify i_cls (
        .lead (in_bytes[BYTE_W-1:0]),
        .cls  (cls)
    );

    vlid_pack i_pack (
        .window (in_bytes),
        .cls    (cls),
        .res    (dec)
    );

    // Handshake: take a window when the output slot is free or freeing.
    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;
    assign pc_next  = pc_q + {{PAD_W{1'b0}}, dec.len};

    // Program counter: reset to start address, step by length on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= start_pc;
        else if (accept) pc_q <= pc_next;
    end

    vlid_out_stage #(.ADDR_W(ADDR_W)) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .res_in  (dec),
        .pc_in   (pc_q),
        .next_in (pc_next),
        .drain   (out_ready),
        .valid   (out_valid),
        .res_q   (held),
        .pc_q    (out_pc),
        .next_q  (out_next_pc)
    );

    assign fetch_pc = pc_q;
    assign out_word = held.word;
    assign out_ext  = held.ext;
    assign out_len  = held.len;
endmodule

// File: rtl/vlid_fetch_decoder_chk.sv
// Port-level properties of the fetch decoder, bound into the top.
module vlid_fetch_decoder_chk
    import vlid_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic [BYTE_W-1:0] out_ext,
    input logic [LEN_W-1:0]  out_len,
    input logic [ADDR_W-1:0] out_pc,
    input logic [ADDR_W-1:0] out_next_pc
);
    localparam int PAD_W = ADDR_W - LEN_W;

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= 3'd1 && out_len <= 3'd5)); // R9
    AST_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_next_pc == out_pc + {{PAD_W{1'b0}}, out_len}); // R9
    AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fetch_pc == out_next_pc); // R9
    AST_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len != 3'd5) |-> out_ext == '0); // R8
    AST_ONE_BYTE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == 3'd1) |-> out_word[31:8] == '0); // R2
    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_ext)
                                       && $stable(out_len) && $stable(out_pc))); // R10
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && in_valid) |=> out_valid); // R11
endmodule

bind vlid_fetch_decoder vlid_fetch_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .fetch_pc    (fetch_pc),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_word    (out_word),
    .out_ext     (out_ext),
    .out_len     (out_len),
    .out_pc      (out_pc),
    .out_next_pc (out_next_pc)
);

// File: tb/test_vlid_fetch_decoder.sv
// Sweeps every lead byte in one stream and exercises stall, back-to-back and wrap.
module test_vlid_fetch_decoder;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] start_pc = 19'h12340;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [39:0]   in_bytes = '0;
    logic [AW-1:0] fetch_pc;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [31:0]   out_word;
    logic [7:0]    out_ext;
    logic [2:0]    out_len;
    logic [AW-1:0] out_pc, out_next_pc;

    int n_checks = 0;
    int n_fails  = 0;
    logic [AW-1:0] exp_pc;

    always #5 clk = ~clk;

    vlid_fetch_decoder #(.ADDR_W(AW)) i_vlid_fetch_decoder (
        .clk(clk), .rst_n(rst_n), .start_pc(start_pc),
        .in_valid(in_valid), .in_ready(in_ready), .in_bytes(in_bytes),
        .fetch_pc(fetch_pc), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_ext(out_ext), .out_len(out_len),
        .out_pc(out_pc), .out_next_pc(out_next_pc)
    );

    task automatic check(input string req, input string what,
                         input logic [39:0] got, input logic [39:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [2:0] model_len(input logic [7:0] v);
        if (v inside {8'h80, 8'h85, 8'h8A, 8'h8F}) return 3'd2;
        if (v inside {[8'h00:8'h3F], [8'h80:8'hBF], 8'hEB, 8'hF6, 8'hFE, 8'hFF}) return 3'd1;
        if (v inside {[8'h40:8'h7F], [8'hD0:8'hDB], [8'hE0:8'hEA], [8'hF0:8'hF3]}) return 3'd2;
        if (v == 8'hF7) return 3'd4;
        if (v == 8'hF4) return 3'd5;
        return 3'd3;
    endfunction

    function automatic string req_of(input logic [7:0] v);
        if (v[7:4] == 4'h8) return "R3";
        case (model_len(v))
            3'd1: return "R2";
            3'd2: return "R4";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return (v == 8'hF5) ? "R6" : "R5";
        endcase
    endfunction

    function automatic logic [39:0] fill(input logic [7:0] lead);
        logic [39:0] w;
        w[7:0] = lead;
        for (int k = 1; k < 5; k++) w[k*8 +: 8] = 8'((lead * 7) + (k * 53) + 17);
        return w;
    endfunction

    function automatic logic [31:0] model_word(input logic [39:0] w);
        logic [7:0] b0, b1, b2, b3, b4;
        {b4, b3, b2, b1, b0} = w;
        case (model_len(b0))
            3'd1: return {24'h0, b0};
            3'd2: return {16'h0, b0, b1};
            3'd4: return {b0, b1, b3, b2};
            3'd5: return {b0, b1, b4, b3};
            default: return (b0 == 8'hF5) ? {8'h0, b0, b1, b2} : {8'h0, b0, b2, b1};
        endcase
    endfunction

    // Issue one window, check the decoded result, then drain it.
    task automatic one_op(input logic [7:0] lead);
        logic [39:0] w = fill(lead);
        logic [2:0]  el = model_len(lead);
        logic [AW-1:0] en = exp_pc + AW'(el);
        string r = req_of(lead);
        @(negedge clk);
        in_bytes = w; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check(r, "len",  40'(out_len),  40'(el));
        check(r, "word", 40'(out_word), 40'(model_word(w)));
        check("R8", "ext", 40'(out_ext), (el == 3'd5) ? 40'(w[23:16]) : 40'h0);
        check("R9", "out_pc", 40'(out_pc), 40'(exp_pc));
        check("R9", "next_pc", 40'(out_next_pc), 40'(en));
        check("R9", "fetch_pc", 40'(fetch_pc), 40'(en));
        exp_pc = en;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic do_reset(input logic [AW-1:0] sp);
        @(negedge clk);
        rst_n = 1'b0; start_pc = sp; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        exp_pc = sp;
        check("R1", "out_valid", 40'(out_valid), 40'h0);
        check("R1", "in_ready", 40'(in_ready), 40'h1);
        check("R1", "fetch_pc", 40'(fetch_pc), 40'(sp));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] held_word;
        logic [AW-1:0] held_pc;
        do_reset(19'h12340);

        // Full sweep of all lead bytes in one continuous stream (R2-R9).
        for (int v = 0; v < 256; v++) one_op(8'(v));

        // Stall: output held, no acceptance, PC frozen (R10).
        one_op(8'hF7);
        @(negedge clk);
        in_bytes = fill(8'hC3); in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        held_word = out_word; held_pc = fetch_pc;
        check("R10", "word after load", 40'(held_word), 40'(model_word(fill(8'hC3))));
        in_bytes = fill(8'hF4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10", "in_ready stalled", 40'(in_ready), 40'h0);
            check("R10", "word held", 40'(out_word), 40'(held_word));
            check("R10", "fetch_pc held", 40'(fetch_pc), 40'(held_pc));
        end
        // Drain and accept in the same cycle (R11).
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "valid back-to-back", 40'(out_valid), 40'h1);
        check("R11", "word new", 40'(out_word), 40'(model_word(fill(8'hF4))));
        check("R11", "out_pc new", 40'(out_pc), 40'(held_pc));
        check("R11", "fetch_pc new", 40'(fetch_pc), 40'(held_pc + 19'd5));
        @(negedge clk);
        out_ready = 1'b0;
        check("R11", "drained", 40'(out_valid), 40'h0);

        // Wrap at the top of the 19-bit space (R9).
        do_reset(19'h7FFFE);
        one_op(8'hF4);
        check("R9", "wrapped pc", 40'(fetch_pc), 40'h3);
        one_op(8'h85);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule